// File: doc/BRIEF.md
# Serial Receive Channel with Error Detection

This block is the receive half of one asynchronous serial channel. It watches a serial input line and counts an enable pulse that arrives sixteen times per bit period. It rejects start bits that do not last, and assembles characters of 5 to 8 data bits, least significant bit first. An optional parity bit is checked, and so is the stop bit. Each finished character goes first into a single holding stage and then into an eight-entry queue. Every entry carries its own parity, framing and break flags alongside the data byte.

A host drains the queue through a read port that shows the oldest entry at all times. A read-enable pulse removes that entry. When the queue holds eight entries, the block raises its active-low request-to-send output, which tells the remote sender to pause. If the queue and the holding stage are both full when another character completes, the newest character is lost. A sticky overrun flag then stays set until the host clears it. When the whole character time, stop position included, arrives as zeros, the block stores one break entry. It then waits for the line to go high before it looks for a new start bit.

The line input must already be synchronous to `clk`. The format inputs must stay stable while a character is being received.

The frame state machine has six states:
- HUNT: waits for a low level on a tick and moves to START_CHECK.
- START_CHECK: samples the line on the eighth tick. If the line is high it goes back to HUNT. If it is low it moves to DATA.
- DATA: samples each bit on the sixteenth tick after the previous sample. After the last data bit it moves to PARITY when parity is enabled, otherwise to STOP.
- PARITY: samples once and moves to STOP.
- STOP: samples once and moves either to BREAK_WAIT (the whole frame was zero) or to HUNT.
- BREAK_WAIT: moves to HUNT on the first tick at which the line is high.

Top module: `serial_rx_channel`

## Requirements
- R1: After a low level is seen on a tick, the line is sampled again on the eighth following tick. If it is high, the start is dropped: no entry is produced, and hunting resumes.
- R2: Data bits are sampled every sixteen ticks after the start sample, least significant bit first. The length comes from `cfg_len`: 00=5, 01=6, 10=7, 11=8 bits. Unused upper bits of the stored byte read as zero.
- R3: Parity is set by `cfg_par`: 00 none, 01 even, 10 odd, 11 forced to the value of `cfg_par_force`. A mismatch sets the entry's parity flag.
- R4: A stop bit sampled low sets the entry's framing flag.
- R5: A frame whose data, parity and stop positions are all low stores one entry with data 0x00, break flag 1, framing flag 1 and parity flag 0. Nothing more is stored until the line has returned high.
- R6: Entries leave in arrival order. The oldest entry is shown on `rd_data`, `rd_perr`, `rd_ferr` and `rd_brk` while `rx_ready` is 1. A `rd_en` pulse removes it, and `rd_en` while empty has no effect.
- R7: A ninth character is kept in the holding stage while the queue is full (`fifo_full`=1). It enters the queue on the clock after a read.
- R8: A character that completes while the queue and the holding stage are both full is discarded and sets `overrun`. `overrun` stays set until `ovr_clr` is pulsed.
- R9: `rts_n` is 1 while the queue holds eight entries and 0 otherwise.
- R10: After reset the queue is empty, `rts_n`=0, `overrun`=0, and the receiver is hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable, sixteen per bit period |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code |
| cfg_par | input | 2 | Parity mode code |
| cfg_par_force | input | 1 | Expected parity bit in forced mode |
| rd_en | input | 1 | Remove the oldest entry |
| rd_data | output | 8 | Data of the oldest entry |
| rd_perr | output | 1 | Parity flag of the oldest entry |
| rd_ferr | output | 1 | Framing flag of the oldest entry |
| rd_brk | output | 1 | Break flag of the oldest entry |
| rx_ready | output | 1 | Queue holds at least one entry |
| fifo_full | output | 1 | Queue holds eight entries |
| overrun | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| rts_n | output | 1 | Active-low request to send |

## Verification
The cycle-level properties are checked on every clock. `rts_n` can only be high while an entry is present. `rts_n` and `rx_ready` can fall only after a read. `overrun` is sticky, and it can rise only while the queue is full. A break entry always shows zero data with the framing flag set and the parity flag clear. Whether bits are sampled at mid-bit, whether a short low pulse is dropped, the parity arithmetic for each mode, and the ordering of entries through the holding stage can only be shown by the bench. Its scenarios drive whole frames and compare the result against a queue model.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP,
        ST_BRKWAIT
    } rx_state_e;

    localparam logic [1:0] PAR_NONE  = 2'b00;
    localparam logic [1:0] PAR_EVEN  = 2'b01;
    localparam logic [1:0] PAR_ODD   = 2'b10;
    localparam logic [1:0] PAR_FORCE = 2'b11;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_entry_t;

endpackage

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
    import srx_pkg::*;
#(
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_par_force,
    output logic       frm_valid,
    output rx_entry_t  frm_entry
);

    localparam int CW = $clog2(OVERSAMPLE);
    localparam logic [CW-1:0] MID_LAST = CW'(OVERSAMPLE / 2 - 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OVERSAMPLE - 1);

    rx_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_last;
    logic [2:0]    bit_q;
    logic [2:0]    last_bit;
    logic [7:0]    shift_q;
    logic          par_acc_q;
    logic          zero_q;
    logic          perr_q;
    logic          par_en;
    logic          par_bad;
    logic          sample;
    logic          valid_q;
    rx_entry_t     entry_q;

    // data length code 0..3 maps to bit indices 4..7
    assign last_bit = {1'b1, cfg_len};
    assign par_en   = (cfg_par != PAR_NONE);
    assign cnt_last = (state_q == ST_START) ? MID_LAST : BIT_LAST;
    assign sample   = tick && (cnt_q == cnt_last);

    always_comb begin
        unique case (cfg_par)
            PAR_EVEN:  par_bad = par_acc_q ^ rxd;
            PAR_ODD:   par_bad = ~(par_acc_q ^ rxd);
            PAR_FORCE: par_bad = (rxd != cfg_par_force);
            default:   par_bad = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (tick && !rxd) state_d = ST_START;
            ST_START:   if (sample) state_d = rxd ? ST_HUNT : ST_DATA;
            ST_DATA:    if (sample && (bit_q == last_bit))
                            state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY:  if (sample) state_d = ST_STOP;
            ST_STOP:    if (sample)
                            state_d = (zero_q && !rxd) ? ST_BRKWAIT : ST_HUNT;
            ST_BRKWAIT: if (tick && rxd) state_d = ST_HUNT;
            default:    state_d = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // sampling datapath and frame outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            bit_q     <= '0;
            shift_q   <= '0;
            par_acc_q <= 1'b0;
            zero_q    <= 1'b0;
            perr_q    <= 1'b0;
            valid_q   <= 1'b0;
            entry_q   <= '0;
        end else begin
            valid_q <= 1'b0;
            if ((state_d != state_q) || sample || (state_q == ST_HUNT)
                || (state_q == ST_BRKWAIT)) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (sample) begin
                unique case (state_q)
                    ST_START: begin
                        shift_q   <= '0;
                        bit_q     <= '0;
                        par_acc_q <= 1'b0;
                        zero_q    <= 1'b1;
                        perr_q    <= 1'b0;
                    end
                    ST_DATA: begin
                        shift_q[bit_q] <= rxd;
                        bit_q          <= bit_q + 3'd1;
                        par_acc_q      <= par_acc_q ^ rxd;
                        zero_q         <= zero_q & ~rxd;
                    end
                    ST_PARITY: begin
                        perr_q <= par_bad;
                        zero_q <= zero_q & ~rxd;
                    end
                    ST_STOP: begin
                        valid_q       <= 1'b1;
                        entry_q.brk   <= zero_q & ~rxd;
                        entry_q.ferr  <= ~rxd;
                        entry_q.perr  <= perr_q & ~(zero_q & ~rxd);
                        entry_q.data  <= shift_q;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign frm_valid = valid_q;
    assign frm_entry = entry_q;

endmodule

// File: rtl/srx_hold_stage.sv
module srx_hold_stage
    import srx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      frm_valid,
    input  rx_entry_t frm_entry,
    input  logic      fifo_full,
    input  logic      ovr_clr,
    output logic      push,
    output rx_entry_t push_entry,
    output logic      overrun
);

    logic      hold_vld_q;
    rx_entry_t hold_q;
    logic      ovr_q;
    logic      ovr_set;

    assign push    = hold_vld_q && !fifo_full;
    assign ovr_set = frm_valid && hold_vld_q && !push;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
            ovr_q      <= 1'b0;
        end else begin
            if (frm_valid && !ovr_set) begin
                hold_q     <= frm_entry;
                hold_vld_q <= 1'b1;
            end else if (push) begin
                hold_vld_q <= 1'b0;
            end
            if (ovr_set) begin
                ovr_q <= 1'b1;
            end else if (ovr_clr) begin
                ovr_q <= 1'b0;
            end
        end
    end

    assign push_entry = hold_q;
    assign overrun    = ovr_q;

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);

    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [CNTW-1:0]  count_q;
    logic             do_push, do_pop;

    assign full    = (count_q == CNT_FULL);
    assign empty   = (count_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr_q];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        always_ff @(posedge clk) begin
            if (do_push && (wr_ptr_q == AW'(gi))) begin
                mem[gi] <= push_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
                rd_ptr_q <= (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/serial_rx_channel.sv
module serial_rx_channel
    import srx_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick16,
    input  logic       rxd,
    input  logic [1:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_par_force,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_perr,
    output logic       rd_ferr,
    output logic       rd_brk,
    output logic       rx_ready,
    output logic       fifo_full,
    output logic       overrun,
    input  logic       ovr_clr,
    output logic       rts_n
);

    localparam int ENTRY_W = $bits(rx_entry_t);

    logic             frm_valid;
    rx_entry_t        frm_entry;
    logic             push;
    rx_entry_t        push_entry;
    logic [ENTRY_W-1:0] head_v;
    rx_entry_t        head_e;
    logic             q_full, q_empty;

    srx_frame_fsm #(
        .OVERSAMPLE(OVERSAMPLE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick16),
        .rxd          (rxd),
        .cfg_len      (cfg_len),
        .cfg_par      (cfg_par),
        .cfg_par_force(cfg_par_force),
        .frm_valid    (frm_valid),
        .frm_entry    (frm_entry)
    );

    srx_hold_stage u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_valid (frm_valid),
        .frm_entry (frm_entry),
        .fifo_full (q_full),
        .ovr_clr   (ovr_clr),
        .push      (push),
        .push_entry(push_entry),
        .overrun   (overrun)
    );

    srx_fifo #(
        .DEPTH(FIFO_DEPTH),
        .WIDTH(ENTRY_W)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_data(ENTRY_W'(push_entry)),
        .pop      (rd_en),
        .head     (head_v),
        .full     (q_full),
        .empty    (q_empty)
    );

    assign head_e    = rx_entry_t'(head_v);
    assign rd_data   = q_empty ? 8'h00 : head_e.data;
    assign rd_perr   = !q_empty && head_e.perr;
    assign rd_ferr   = !q_empty && head_e.ferr;
    assign rd_brk    = !q_empty && head_e.brk;
    assign rx_ready  = !q_empty;
    assign fifo_full = q_full;
    assign rts_n     = q_full;

endmodule

// File: rtl/srx_rx_checks.sv
module srx_rx_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_en,
    input logic       rx_ready,
    input logic       fifo_full,
    input logic       overrun,
    input logic       ovr_clr,
    input logic       rts_n,
    input logic       rd_brk,
    input logic       rd_ferr,
    input logic       rd_perr,
    input logic [7:0] rd_data
);

    // R9
    rts_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |-> rx_ready);

    // R9
    rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rts_n) |-> $past(rd_en));

    // R6
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_ready) |-> $past(rd_en));

    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R8
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(fifo_full));

    // R5
    brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rd_brk) |-> (rd_data == 8'h00 && rd_ferr && !rd_perr));

endmodule

bind serial_rx_channel srx_rx_checks i_checks (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rx_ready (rx_ready),
    .fifo_full(fifo_full),
    .overrun  (overrun),
    .ovr_clr  (ovr_clr),
    .rts_n    (rts_n),
    .rd_brk   (rd_brk),
    .rd_ferr  (rd_ferr),
    .rd_perr  (rd_perr),
    .rd_data  (rd_data)
);

// File: tb/test_serial_rx_channel.sv
`timescale 1ns/1ps
module test_serial_rx_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_par_force = 1'b0;
    logic       rd_en = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic       rd_perr, rd_ferr, rd_brk;
    logic       rx_ready, fifo_full, overrun, rts_n;

    int  checks = 0;
    int  fails = 0;
    bit  sync = 0;
    bit  done = 0;
    logic [10:0] mq[$];
    bit  m_ovr = 0;

    serial_rx_channel i_serial_rx_channel (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_par_force(cfg_par_force),
        .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
        .rd_ferr(rd_ferr), .rd_brk(rd_brk), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .overrun(overrun), .ovr_clr(ovr_clr),
        .rts_n(rts_n)
    );

    always #4 clk = ~clk;

    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            tick16 = (ph == 3);
            ph = (ph + 1) % 4;
        end
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // reference comparison on every clock while the model is settled
    always @(negedge clk) begin
        if (sync && !done) begin
            chk(rx_ready == (mq.size() > 0), "R6 ready", rx_ready, mq.size() > 0);
            chk(fifo_full == (mq.size() >= 8), "R7 full", fifo_full, mq.size() >= 8);
            chk(rts_n == (mq.size() >= 8), "R9 rts", rts_n, mq.size() >= 8);
            chk(overrun == m_ovr, "R8 overrun", overrun, m_ovr);
            if (mq.size() > 0)
                chk({rd_brk, rd_ferr, rd_perr, rd_data} == mq[0], "R6 head",
                    {rd_brk, rd_ferr, rd_perr, rd_data}, mq[0]);
        end
    end

    task automatic wait_tick();
        @(posedge clk);
        while (!tick16) @(posedge clk);
    endtask

    task automatic drive(input logic v, input int n);
        @(negedge clk);
        rxd = v;
        repeat (n) wait_tick();
    endtask

    task automatic idle(input int n);
        repeat (n) wait_tick();
        @(negedge clk);
    endtask

    task automatic model_push(input logic [10:0] e);
        if (mq.size() < 9) mq.push_back(e);
        else m_ovr = 1;
    endtask

    task automatic send_frame(input logic [7:0] d, input bit flip, input bit stopv);
        int nb;
        logic [7:0] md;
        logic pb;
        nb = 5 + int'(cfg_len);
        md = d & 8'((1 << nb) - 1);
        unique case (cfg_par)
            2'b01:   pb = ^md;
            2'b10:   pb = ~^md;
            default: pb = cfg_par_force;
        endcase
        sync = 0;
        wait_tick();
        drive(1'b0, 16);
        for (int i = 0; i < nb; i++) drive(d[i], 16);
        if (cfg_par != 2'b00) drive(pb ^ flip, 16);
        drive(stopv, 16);
        @(negedge clk);
        rxd = 1'b1;
        idle(12);
        model_push({1'b0, ~stopv, flip && (cfg_par != 2'b00), md});
        sync = 1;
    endtask

    task automatic read_one(input string req);
        sync = 0;
        @(negedge clk);
        if (mq.size() == 0) begin
            chk(0, req, rx_ready, 1);
        end else begin
            chk(rx_ready && ({rd_brk, rd_ferr, rd_perr, rd_data} == mq[0]), req,
                {rd_brk, rd_ferr, rd_perr, rd_data}, mq[0]);
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            void'(mq.pop_front());
            repeat (2) @(negedge clk);
        end
        sync = 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(!rx_ready && !fifo_full && !rts_n && !overrun, "R10 reset",
            {rx_ready, fifo_full, rts_n, overrun}, 0);
        rst_n = 1'b1;
        idle(4);
        chk(!rx_ready && !rts_n, "R10 idle after reset", {rx_ready, rts_n}, 0);
        sync = 1;

        // R2: eight bits, no parity
        cfg_len = 2'b11; cfg_par = 2'b00;
        send_frame(8'hA5, 0, 1);
        send_frame(8'h5A, 0, 1);
        read_one("R2 8N first");
        read_one("R2 8N second");

        // R2 R3: five bits even parity, upper bits dropped
        cfg_len = 2'b00; cfg_par = 2'b01;
        send_frame(8'h13, 0, 1);
        send_frame(8'hFF, 0, 1);
        read_one("R2 5E data");
        read_one("R2 5E masked");

        // R3: seven bits odd parity, good and bad
        cfg_len = 2'b10; cfg_par = 2'b10;
        send_frame(8'h41, 0, 1);
        send_frame(8'h41, 1, 1);
        read_one("R3 odd good");
        read_one("R3 odd bad");

        // R3: six bits forced parity
        cfg_len = 2'b01; cfg_par = 2'b11; cfg_par_force = 1'b1;
        send_frame(8'h2A, 0, 1);
        cfg_par_force = 1'b0;
        send_frame(8'h15, 1, 1);
        read_one("R3 forced good");
        read_one("R3 forced bad");

        // R3: eight bits even parity, bad
        cfg_len = 2'b11; cfg_par = 2'b01;
        send_frame(8'hC3, 1, 1);
        read_one("R3 even bad");

        // R4: framing error then a clean frame
        cfg_par = 2'b00;
        send_frame(8'h81, 0, 0);
        send_frame(8'h42, 0, 1);
        read_one("R4 framing flag");
        read_one("R4 recovery");

        // R1: short low pulse is dropped
        wait_tick();
        drive(1'b0, 7);
        @(negedge clk);
        rxd = 1'b1;
        idle(24);
        chk(!rx_ready, "R1 false start", rx_ready, 0);
        send_frame(8'h66, 0, 1);
        read_one("R1 after false start");

        // R5: break, single entry, then normal frame
        cfg_par = 2'b01;
        sync = 0;
        wait_tick();
        drive(1'b0, 224);
        @(negedge clk);
        rxd = 1'b1;
        idle(12);
        model_push(11'b110_0000_0000);
        sync = 1;
        send_frame(8'h3C, 0, 1);
        read_one("R5 break entry");
        read_one("R5 resume");

        // R6: read while empty has no effect
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk(!rx_ready && !fifo_full, "R6 empty read", rx_ready, 0);
        send_frame(8'h99, 0, 1);
        read_one("R6 order after empty read");

        // R7 R8 R9: fill queue, holding stage, overrun
        cfg_par = 2'b00;
        for (int i = 0; i < 8; i++) send_frame(8'(i + 1), 0, 1);
        chk(rts_n == 1'b1, "R9 rts at eight", rts_n, 1);
        send_frame(8'h09, 0, 1);
        chk(fifo_full && !overrun, "R7 ninth held", {fifo_full, overrun}, 2'b10);
        send_frame(8'h0A, 0, 1);
        chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
        read_one("R7 first after fill");
        chk(fifo_full == 1'b1, "R7 held entry moved in", fifo_full, 1);
        for (int i = 1; i < 9; i++) read_one("R7 drain");
        chk(!rx_ready && !rts_n, "R9 rts after drain", {rx_ready, rts_n}, 0);
        chk(overrun == 1'b1, "R8 sticky", overrun, 1);
        sync = 0;
        @(negedge clk);
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        m_ovr = 0;
        @(negedge clk);
        chk(overrun == 1'b0, "R8 cleared", overrun, 0);
        sync = 1;
        idle(4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule